// File: doc/BRIEF.md
# Metadata Address Translation Buffer

This block is a small fully associative lookup table used by a software monitor that keeps one metadata byte for every 4-byte word of application data. Each application address splits at bit 16. The upper half is a chunk tag. The low half, shifted right by two, is the byte offset inside that chunk's metadata region. A valid entry pairs one chunk tag with the base address of that chunk's metadata region.

A lookup request returns, in the cycle it is accepted, either a hit carrying the metadata base plus the scaled offset, or a miss. On a miss, monitoring software walks its own index tables and then installs the translation through a separate maintenance port. The same port can also remove one translation by tag or empty the whole table.

All table updates take effect at the next clock edge. A lookup in the same cycle as a maintenance operation therefore sees the table as it was before that operation.

Top module: `mtb_top`

## Requirements
- R1: After reset every entry is invalid, so every lookup misses until a fill is made.
- R2: A lookup of address A whose tag A[31:16] matches a valid entry with base B raises hit in the same cycle, with metadata address B + A[15:2] (14-bit offset, zero-extended, modulo 2^32).
- R3: A lookup with no matching entry raises miss, keeps hit low and drives the metadata address to zero. When no request is valid, hit and miss are both low.
- R4: The request port is always ready, and each accepted request gets its result in the same cycle.
- R5: A fill (maintenance code 1) whose tag is not present writes the tag and base into the lowest-numbered invalid entry. The new translation is visible from the next cycle.
- R6: A fill whose tag is already present overwrites that entry's base in place. No second entry with the same tag is ever created.
- R7: A fill of a new tag into a full table replaces the entry selected by a round-robin pointer. The pointer is 0 after reset, advances by one (wrapping at 16) after each such replacement, and does not change on any other operation.
- R8: An invalidate (maintenance code 2) clears the entry holding the given tag from the next cycle and leaves all others untouched. An invalidate of an absent tag changes nothing. The cleared slot is reused by the next fill.
- R9: A flush (maintenance code 3) clears every entry in one cycle.
- R10: A lookup in the same cycle as a fill, invalidate or flush observes the table contents from before that operation.
- R11: Maintenance code 0 is idle and leaves the table unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Lookup can be accepted (always high) |
| req_addr | input | 32 | Application address to translate |
| rsp_hit | output | 1 | Accepted lookup found a translation |
| rsp_miss | output | 1 | Accepted lookup found no translation |
| rsp_maddr | output | 32 | Metadata address on hit, zero otherwise |
| mnt_op | input | 2 | 0 idle, 1 fill, 2 invalidate by tag, 3 flush all |
| mnt_tag | input | 16 | Chunk tag for fill or invalidate |
| mnt_base | input | 32 | Metadata chunk base for fill |

## Verification
The assertions assume that the maintenance inputs hold known values from the first clock edge, with the opcode idle during reset, because several properties look one cycle back at the opcode and tag. They also assume that a lookup arriving right after a fill or invalidate refers to the tag just written or removed, which is the only case where the outcome is fixed without knowing the rest of the table. The stimulus drives every input from time zero and keeps the opcode idle through reset. Random tags come from a pool of 24 values, larger than the table, so hits, misses, in-place overwrites and round-robin replacement all occur often. Directed sequences first fill the table exactly and then check which tag each replacement removes.

// File: rtl/mtb_pkg.sv
package mtb_pkg;

    localparam int unsigned MTB_ADDR_W     = 32;
    localparam int unsigned MTB_CHUNK_BITS = 16;
    localparam int unsigned MTB_WORD_BITS  = 2;
    localparam int unsigned MTB_ENTRIES    = 16;

    typedef enum logic [1:0] {
        MNT_IDLE  = 2'd0,
        MNT_FILL  = 2'd1,
        MNT_INVAL = 2'd2,
        MNT_FLUSH = 2'd3
    } mnt_op_e;

endpackage

// File: rtl/mtb_match.sv
module mtb_match #(
    parameter int unsigned N     = 16,
    parameter int unsigned TAG_W = 16,
    localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]            vld,
    input  logic [N-1:0][TAG_W-1:0] tags,
    input  logic [TAG_W-1:0]        key,
    output logic [N-1:0]            hit_vec,
    output logic                    any_hit,
    output logic [IDX_W-1:0]        hit_idx
);

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hit_vec[g] = vld[g] && (tags[g] == key);
    end

    assign any_hit = |hit_vec;

    always_comb begin
        hit_idx = '0;
        for (int i = 0; i < N; i++) begin
            if (hit_vec[i]) begin
                hit_idx = hit_idx | IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/mtb_pick.sv
module mtb_pick #(
    parameter int unsigned N = 16,
    localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     vld,
    input  logic [IDX_W-1:0] rr_ptr,
    output logic [IDX_W-1:0] victim,
    output logic             full
);

    logic [IDX_W-1:0] free_idx;

    assign full = &vld;

    always_comb begin
        free_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!vld[i]) begin
                free_idx = IDX_W'(i);
            end
        end
    end

    assign victim = full ? rr_ptr : free_idx;

endmodule

// File: rtl/mtb_top.sv
module mtb_top
    import mtb_pkg::*;
#(
    parameter int unsigned ENTRIES    = MTB_ENTRIES,
    parameter int unsigned ADDR_W     = MTB_ADDR_W,
    parameter int unsigned CHUNK_BITS = MTB_CHUNK_BITS,
    parameter int unsigned WORD_BITS  = MTB_WORD_BITS,
    localparam int unsigned TAG_W = ADDR_W - CHUNK_BITS,
    localparam int unsigned OFF_W = CHUNK_BITS - WORD_BITS,
    localparam int unsigned IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rsp_hit,
    output logic              rsp_miss,
    output logic [ADDR_W-1:0] rsp_maddr,
    input  logic [1:0]        mnt_op,
    input  logic [TAG_W-1:0]  mnt_tag,
    input  logic [ADDR_W-1:0] mnt_base
);

    typedef struct packed {
        logic [ENTRIES-1:0]             vld;
        logic [ENTRIES-1:0][TAG_W-1:0]  tag;
        logic [ENTRIES-1:0][ADDR_W-1:0] base;
        logic [IDX_W-1:0]               rr;
    } st_t;

    st_t st_d, st_q;

    mnt_op_e op;
    assign op = mnt_op_e'(mnt_op);

    logic [ENTRIES-1:0] l_hit_vec;
    logic               l_any;
    logic [IDX_W-1:0]   l_idx;
    logic [ENTRIES-1:0] m_hit_vec;
    logic               m_any;
    logic [IDX_W-1:0]   m_idx;
    logic [IDX_W-1:0]   victim;
    logic               full;

    mtb_match #(.N(ENTRIES), .TAG_W(TAG_W)) u_look_match (
        .vld     (st_q.vld),
        .tags    (st_q.tag),
        .key     (req_addr[ADDR_W-1:CHUNK_BITS]),
        .hit_vec (l_hit_vec),
        .any_hit (l_any),
        .hit_idx (l_idx)
    );

    mtb_match #(.N(ENTRIES), .TAG_W(TAG_W)) u_mnt_match (
        .vld     (st_q.vld),
        .tags    (st_q.tag),
        .key     (mnt_tag),
        .hit_vec (m_hit_vec),
        .any_hit (m_any),
        .hit_idx (m_idx)
    );

    mtb_pick #(.N(ENTRIES)) u_pick (
        .vld    (st_q.vld),
        .rr_ptr (st_q.rr),
        .victim (victim),
        .full   (full)
    );

    // lookup path reads registered state only
    logic [ADDR_W-1:0] sel_base;
    logic [ADDR_W-1:0] word_off;

    assign sel_base  = st_q.base[l_idx];
    assign word_off  = ADDR_W'(req_addr[CHUNK_BITS-1:WORD_BITS]);
    assign req_ready = 1'b1;
    assign rsp_hit   = req_valid && l_any;
    assign rsp_miss  = req_valid && !l_any;
    assign rsp_maddr = rsp_hit ? (sel_base + word_off) : '0;

    always_comb begin
        st_d = st_q;
        unique case (op)
            MNT_FILL: begin
                if (m_any) begin
                    st_d.base[m_idx] = mnt_base;
                end else begin
                    st_d.vld[victim]  = 1'b1;
                    st_d.tag[victim]  = mnt_tag;
                    st_d.base[victim] = mnt_base;
                    if (full) begin
                        st_d.rr = (st_q.rr == IDX_W'(ENTRIES - 1)) ? '0 : st_q.rr + 1'b1;
                    end
                end
            end
            MNT_INVAL: begin
                if (m_any) begin
                    st_d.vld[m_idx] = 1'b0;
                end
            end
            MNT_FLUSH: begin
                st_d.vld = '0;
            end
            default: begin
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/mtb_chk.sv
module mtb_chk #(
    parameter int unsigned ENTRIES    = 16,
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned CHUNK_BITS = 16,
    parameter int unsigned WORD_BITS  = 2,
    localparam int unsigned TAG_W = ADDR_W - CHUNK_BITS
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               req_ready,
    input logic [ADDR_W-1:0]  req_addr,
    input logic               rsp_hit,
    input logic               rsp_miss,
    input logic [ADDR_W-1:0]  rsp_maddr,
    input logic [1:0]         mnt_op,
    input logic [TAG_W-1:0]   mnt_tag,
    input logic [ADDR_W-1:0]  mnt_base,
    input logic [ENTRIES-1:0] look_hits
);

    logic [TAG_W-1:0]  req_tag;
    logic [ADDR_W-1:0] req_off;
    assign req_tag = req_addr[ADDR_W-1:CHUNK_BITS];
    assign req_off = ADDR_W'(req_addr[CHUNK_BITS-1:WORD_BITS]);

    AST_ALWAYS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> req_ready); // R4

    AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (rsp_hit != rsp_miss)); // R3

    AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> (!rsp_hit && !rsp_miss)); // R3

    AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_miss |-> (rsp_maddr == '0)); // R3

    AST_UNIQUE_TAG: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(look_hits)); // R6

    AST_FILL_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mnt_op) == 2'd1 && req_valid && req_tag == $past(mnt_tag))
        |-> (rsp_hit && rsp_maddr == $past(mnt_base) + req_off)); // R2

    AST_INVAL_GONE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mnt_op) == 2'd2 && req_valid && req_tag == $past(mnt_tag))
        |-> rsp_miss); // R8

    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mnt_op) == 2'd3 && req_valid) |-> rsp_miss); // R9

    AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!rst_n) && req_valid) |-> rsp_miss); // R1

endmodule

bind mtb_top mtb_chk #(
    .ENTRIES    (ENTRIES),
    .ADDR_W     (ADDR_W),
    .CHUNK_BITS (CHUNK_BITS),
    .WORD_BITS  (WORD_BITS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_addr  (req_addr),
    .rsp_hit   (rsp_hit),
    .rsp_miss  (rsp_miss),
    .rsp_maddr (rsp_maddr),
    .mnt_op    (mnt_op),
    .mnt_tag   (mnt_tag),
    .mnt_base  (mnt_base),
    .look_hits (l_hit_vec)
);

// File: tb/mtb_top_tb.sv
`timescale 1ns/1ps
module mtb_top_tb;

    localparam int N = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic        rsp_hit;
    logic        rsp_miss;
    logic [31:0] rsp_maddr;
    logic [1:0]  mnt_op = 2'd0;
    logic [15:0] mnt_tag = '0;
    logic [31:0] mnt_base = '0;

    always #2.5 clk = ~clk;

    mtb_top u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_addr  (req_addr),
        .rsp_hit   (rsp_hit),
        .rsp_miss  (rsp_miss),
        .rsp_maddr (rsp_maddr),
        .mnt_op    (mnt_op),
        .mnt_tag   (mnt_tag),
        .mnt_base  (mnt_base)
    );

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // reference model of the table
    bit          m_vld [N];
    logic [15:0] m_tag [N];
    logic [31:0] m_base[N];
    int          m_rr;

    function automatic void model_reset();
        for (int i = 0; i < N; i++) begin
            m_vld[i] = 0; m_tag[i] = '0; m_base[i] = '0;
        end
        m_rr = 0;
    endfunction

    function automatic int model_find(input logic [15:0] t);
        for (int i = 0; i < N; i++) begin
            if (m_vld[i] && m_tag[i] == t) return i;
        end
        return -1;
    endfunction

    function automatic void model_apply(input logic [1:0] op, input logic [15:0] t, input logic [31:0] b);
        int k;
        int f;
        k = model_find(t);
        case (op)
            2'd1: begin
                if (k >= 0) begin
                    m_base[k] = b;
                end else begin
                    f = -1;
                    for (int i = N - 1; i >= 0; i--) if (!m_vld[i]) f = i;
                    if (f < 0) begin
                        f = m_rr;
                        m_rr = (m_rr + 1) % N;
                    end
                    m_vld[f] = 1; m_tag[f] = t; m_base[f] = b;
                end
            end
            2'd2: if (k >= 0) m_vld[k] = 0;
            2'd3: for (int i = 0; i < N; i++) m_vld[i] = 0;
            default: ;
        endcase
    endfunction

    task automatic check(input bit ok, input string rq, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    task automatic step(input logic [1:0] op, input logic [15:0] t, input logic [31:0] b,
                        input logic rv, input logic [31:0] a, input string rq);
        int k;
        logic [31:0] exp_addr;
        @(negedge clk);
        mnt_op = op; mnt_tag = t; mnt_base = b;
        req_valid = rv; req_addr = a;
        #1;
        check(req_ready === 1'b1, "R4", "ready", {31'b0, req_ready}, 32'd1);
        if (rv) begin
            k = model_find(a[31:16]);
            exp_addr = (k >= 0) ? m_base[k] + {18'b0, a[15:2]} : 32'd0;
            check(rsp_hit === (k >= 0), rq, "hit", {31'b0, rsp_hit}, {31'b0, k >= 0});
            check(rsp_miss === (k < 0), rq, "miss", {31'b0, rsp_miss}, {31'b0, k < 0});
            check(rsp_maddr === exp_addr, rq, "maddr", rsp_maddr, exp_addr);
        end else begin
            check(rsp_hit === 1'b0 && rsp_miss === 1'b0, "R3", "idle flags",
                  {30'b0, rsp_hit, rsp_miss}, 32'd0);
        end
        @(posedge clk);
        model_apply(op, t, b);
    endtask

    task automatic look(input logic [31:0] a, input string rq);
        step(2'd0, 16'h0, 32'h0, 1'b1, a, rq);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0123));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: empty after reset; R3 idle port quiet
        look(32'h1000_0040, "R1");
        step(2'd0, 16'h0, 32'h0, 1'b0, 32'h0, "R3");

        // R10: fill with same-cycle lookup sees old state; R5 then visible
        step(2'd1, 16'h1000, 32'h8000_0000, 1'b1, 32'h1000_0040, "R10");
        look(32'h1000_FFFC, "R5");
        look(32'h1000_0007, "R2");
        look(32'h1001_0000, "R3");

        // R6: refill same tag overwrites in place
        step(2'd1, 16'h1000, 32'hFFFF_FFF0, 1'b0, 32'h0, "R6");
        look(32'h1000_0100, "R6");

        // fill remaining 15 slots: table exactly full if no duplicate exists
        for (int i = 1; i < N; i++)
            step(2'd1, 16'h2000 + 16'(i), 32'h0100_0000 * i, 1'b0, 32'h0, "R5");
        for (int i = 1; i < N; i++)
            look({16'h2000 + 16'(i), 16'h0010}, "R5");

        // R7: new tag evicts slot 0 (tag 1000)
        step(2'd1, 16'h3000, 32'hA000_0000, 1'b0, 32'h0, "R7");
        look(32'h1000_0000, "R7");
        look(32'h3000_0004, "R7");
        look(32'h2001_0000, "R7");
        // next eviction takes slot 1 (tag 2001)
        step(2'd1, 16'h3001, 32'hA100_0000, 1'b0, 32'h0, "R7");
        look(32'h2001_0000, "R7");
        look(32'h2002_0000, "R7");

        // R8: invalidate, same-cycle lookup still hits (R10)
        step(2'd2, 16'h2005, 32'h0, 1'b1, 32'h2005_0020, "R10");
        look(32'h2005_0020, "R8");
        step(2'd2, 16'h7777, 32'h0, 1'b0, 32'h0, "R8");
        look(32'h2006_0000, "R8");
        // freed slot reused without moving pointer, then eviction hits slot 2
        step(2'd1, 16'h3002, 32'hA200_0000, 1'b0, 32'h0, "R8");
        look(32'h3002_0008, "R8");
        step(2'd1, 16'h3003, 32'hA300_0000, 1'b0, 32'h0, "R7");
        look(32'h2002_0000, "R7");
        look(32'h2003_0000, "R7");

        // R11: idle cycles keep contents
        repeat (3) step(2'd0, 16'h2003, 32'h1234_5678, 1'b0, 32'h0, "R11");
        look(32'h2003_ABCC, "R11");

        // R9: flush, same-cycle lookup hits, then all miss
        step(2'd3, 16'h0, 32'h0, 1'b1, 32'h3000_0000, "R10");
        look(32'h3000_0000, "R9");
        look(32'h2003_0000, "R9");

        // random mix
        for (int n = 0; n < 4000; n++) begin
            int r;
            logic [1:0]  op;
            logic [15:0] t;
            logic [15:0] lt;
            r  = int'($urandom % 100);
            op = (r < 45) ? 2'd0 : (r < 85) ? 2'd1 : (r < 98) ? 2'd2 : 2'd3;
            t  = 16'h4000 + 16'($urandom % 24);
            lt = 16'h4000 + 16'($urandom % 24);
            step(op, t, $urandom, 1'($urandom % 4 != 0), {lt, 16'($urandom)}, "R2");
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule